// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the processor-facing half of an I2C master. A 32-bit register bus, with one-cycle write and read strobes, reaches a control word, a few transfer configuration words, a sticky status word and two byte-wide FIFOs. Bytes written by software queue up for a separate bus engine, and bytes the engine receives queue up for software. The engine sees the head of the transmit queue, a free-space flag on the receive queue and the configuration fields as plain wires. It reports back through busy, done and NACK signals and the sampled SDA and SCL line levels.

One interrupt output combines three sources: a sticky transfer-done flag, a receive level that has reached a programmable almost-full mark, and a transmit level that has fallen to a programmable almost-empty mark. Each level source has its own enable, and a global enable gates the output. Software can therefore drain or refill the queues in bursts while a long transfer is in progress.

Register map (byte offsets): control 0x00, device address 0x04, transfer length 0x08, transmit data 0x0C (write only), receive data 0x10 (read only), status 0x14, SCL divider low word 0x20, SCL divider high word 0x24, START hold count 0x28, FIFO flush 0x2C.

Top module: `i2c_fifo_regs`

## Requirements
- R1: After reset, every register reads zero except status. Status reads the TX-empty bit (bit 3) together with the live line levels. The interrupt is low, no transmit byte is offered (`tx_avail`=0) and the receive queue has room (`rx_room`=1).
- R2: The control word keeps start (bit 0), global interrupt enable (bit 1), direction (bit 3), empty-level enable (bit 9), full-level enable (bit 10), almost-empty level (bits 15:12), almost-full level (bits 19:16) and STOP enable (bit 20). All other bits read back 0. Start, direction and STOP enable drive `cfg_start`, `cfg_rd_dir` and `cfg_stop_en`.
- R3: The device address (0x04, 16 bits), transfer length (0x08, 16 bits), divider words (0x20 and 0x24, 32 bits each) and START hold (0x28, 16 bits) read back what was written, truncated to their width, and drive their configuration outputs.
- R4: Each write to 0x0C pushes write-data bits 7:0 into a 16-entry transmit queue. The engine receives the bytes in write order on `tx_head` while `tx_avail` is high, and `tx_take` removes one byte. A write to a full queue is dropped.
- R5: Each read of 0x10 pops one byte from a 16-entry receive queue and returns it in bits 7:0, in the order the engine pushed with `rx_put`. A read of an empty queue returns 0 and leaves the queue unchanged. A push to a full queue is dropped, and `rx_room` is low while the queue is full.
- R6: Status bit 0 mirrors `eng_busy`, bit 3 is set while the transmit queue is empty, bit 4 is set while the receive queue is full, bit 20 mirrors `scl_in` and bit 21 mirrors `sda_in`.
- R7: An `eng_done` pulse sets the pending flag (status bit 2), and an `eng_nack` pulse sets the NACK flag (status bit 1). Each flag stays set until a status write carries 0 in its bit; a 1 in that bit leaves the flag alone. A set and a clear in the same cycle leave the flag set.
- R8: A write of 0x2C with bit 0 set empties both queues. A write with bit 0 clear has no effect.
- R9: With the full-level enable set, the full-level condition holds while the receive queue holds at least the almost-full level of bytes.
- R10: With the empty-level enable set, the empty-level condition holds while the transmit queue holds no more than the almost-empty level of bytes.
- R11: `irq` is a register. One cycle after the sources change, it equals the global enable ANDed with the OR of pending, the full-level condition and the empty-level condition. NACK alone never raises it.
- R12: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_head | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Engine removes the head transmit byte |
| rx_put | input | 1 | Engine pushes a received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive queue not full |
| eng_busy | input | 1 | Engine is running a transfer |
| eng_done | input | 1 | Transfer finished pulse |
| eng_nack | input | 1 | NACK received pulse |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| cfg_start | output | 1 | Start field |
| cfg_rd_dir | output | 1 | Direction field, 1 = read |
| cfg_stop_en | output | 1 | STOP enable field |
| cfg_dev_addr | output | 16 | Device address word |
| cfg_xfer_len | output | 16 | Transfer length |
| cfg_div_lo | output | 32 | SCL divider low word |
| cfg_div_hi | output | 32 | SCL divider high word |
| cfg_hold | output | 16 | START hold count |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties:
- the queue occupancy never exceeds the depth;
- pushes to a full queue and pops from an empty queue leave the occupancy unchanged;
- a flush always empties a queue;
- the pending flag is sticky and a set always wins over a clear;
- the interrupt is low whenever the global enable was low, and high one cycle after any enabled source;
- unmapped reads return zero.

Only the bench scenarios can show the rest: byte ordering through both queues, the exact bit position of each control and status field, the truncation of configuration words, and the full threshold behaviour. For the thresholds, the bench sweeps every almost-full and almost-empty level against every occupancy from zero to the depth.

// File: rtl/i2cfe_pkg.sv
// Package: register offsets, field positions and the control word type
// shared by the I2C register front end. Assumes a 32-bit register bus.
package i2cfe_pkg;

    localparam int REG_W = 32;
    localparam int LVL_W = 4;

    // Register byte offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_ADDR   = 'h04;
    localparam int OFS_LEN    = 'h08;
    localparam int OFS_TXD    = 'h0C;
    localparam int OFS_RXD    = 'h10;
    localparam int OFS_STAT   = 'h14;
    localparam int OFS_DIV_LO = 'h20;
    localparam int OFS_DIV_HI = 'h24;
    localparam int OFS_HOLD   = 'h28;
    localparam int OFS_FLUSH  = 'h2C;

    // Control word bit positions
    localparam int CB_START  = 0;
    localparam int CB_IEN    = 1;
    localparam int CB_DIR    = 3;
    localparam int CB_AEIE   = 9;
    localparam int CB_AFIE   = 10;
    localparam int CB_AE_LSB = 12;
    localparam int CB_AF_LSB = 16;
    localparam int CB_STOP   = 20;

    // Status word bit positions
    localparam int SB_BUSY    = 0;
    localparam int SB_NACK    = 1;
    localparam int SB_PEND    = 2;
    localparam int SB_TXEMPTY = 3;
    localparam int SB_RXFULL  = 4;
    localparam int SB_SCL     = 20;
    localparam int SB_SDA     = 21;

    typedef struct packed {
        logic             stop_en;
        logic [LVL_W-1:0] af_lvl;
        logic [LVL_W-1:0] ae_lvl;
        logic             af_ie;
        logic             ae_ie;
        logic             rd_dir;
        logic             irq_en;
        logic             start;
    } ctrl_t;

    // Place the control fields at their bus bit positions
    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[CB_START]            = c.start;
        w[CB_IEN]              = c.irq_en;
        w[CB_DIR]              = c.rd_dir;
        w[CB_AEIE]             = c.ae_ie;
        w[CB_AFIE]             = c.af_ie;
        w[CB_AE_LSB +: LVL_W]  = c.ae_lvl;
        w[CB_AF_LSB +: LVL_W]  = c.af_lvl;
        w[CB_STOP]             = c.stop_en;
        return w;
    endfunction

    // Extract the control fields from a bus word
    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.start   = w[CB_START];
        c.irq_en  = w[CB_IEN];
        c.rd_dir  = w[CB_DIR];
        c.ae_ie   = w[CB_AEIE];
        c.af_ie   = w[CB_AFIE];
        c.ae_lvl  = w[CB_AE_LSB +: LVL_W];
        c.af_lvl  = w[CB_AF_LSB +: LVL_W];
        c.stop_en = w[CB_STOP];
        return c;
    endfunction

endpackage

// File: rtl/i2cfe_byte_fifo.sv
// Module: synchronous FIFO with an occupancy count.
// Pushes to a full FIFO and pops from an empty FIFO are ignored, and
// flush has priority over both. The head entry is shown combinationally.
// Assumes DEPTH >= 2. Storage is not reset; only pointers and count are.
module i2cfe_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           empty,
    output logic                           full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign level   = cnt;
    assign head    = mem[rd_ptr];

    // Write the accepted byte into storage
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R4: a lone push into a full FIFO is dropped
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (cnt == CNT_W'(DEPTH)));

    // R5: a lone pop from an empty FIFO leaves it empty
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (cnt == '0));

    // R8: a flush always empties the FIFO
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

endmodule

// File: rtl/i2cfe_regs.sv
// Module: register decode, configuration storage and sticky status.
// Turns bus strobes into FIFO push/pop/flush pulses and registers read
// data one cycle after the read strobe. Assumes one-cycle strobes and
// ADDR_W wide enough to hold the largest offset (0x2C).
module i2cfe_regs
    import i2cfe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DEVADDR_W = 16,
    parameter int LEN_W     = 16,
    parameter int HOLD_W    = 16,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 tx_push,
    output logic [DATA_W-1:0]    tx_wbyte,
    input  logic                 tx_empty,
    output logic                 rx_pop,
    input  logic [DATA_W-1:0]    rx_head,
    input  logic                 rx_empty,
    input  logic                 rx_full,
    output logic                 fifo_flush,
    input  logic                 eng_busy,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    input  logic                 sda_in,
    input  logic                 scl_in,
    output ctrl_t                ctrl,
    output logic                 pend,
    output logic [DEVADDR_W-1:0] dev_addr,
    output logic [LEN_W-1:0]     xfer_len,
    output logic [REG_W-1:0]     div_lo,
    output logic [REG_W-1:0]     div_hi,
    output logic [HOLD_W-1:0]    hold
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ADDR   = ADDR_W'(OFS_ADDR);
    localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_TXD    = ADDR_W'(OFS_TXD);
    localparam logic [ADDR_W-1:0] A_RXD    = ADDR_W'(OFS_RXD);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_DIV_LO = ADDR_W'(OFS_DIV_LO);
    localparam logic [ADDR_W-1:0] A_DIV_HI = ADDR_W'(OFS_DIV_HI);
    localparam logic [ADDR_W-1:0] A_HOLD   = ADDR_W'(OFS_HOLD);
    localparam logic [ADDR_W-1:0] A_FLUSH  = ADDR_W'(OFS_FLUSH);

    ctrl_t                ctrl_q;
    logic                 nack_q;
    logic                 pend_q;
    logic [DEVADDR_W-1:0] dev_addr_q;
    logic [LEN_W-1:0]     len_q;
    logic [REG_W-1:0]     div_lo_q;
    logic [REG_W-1:0]     div_hi_q;
    logic [HOLD_W-1:0]    hold_q;
    logic [REG_W-1:0]     rd_word;
    logic [REG_W-1:0]     stat_word;
    logic                 rd_mapped;
    logic                 stat_wr;

    assign stat_wr    = reg_wr && (reg_addr == A_STAT);
    assign tx_push    = reg_wr && (reg_addr == A_TXD);
    assign tx_wbyte   = reg_wdata[DATA_W-1:0];
    assign rx_pop     = reg_rd && (reg_addr == A_RXD);
    assign fifo_flush = reg_wr && (reg_addr == A_FLUSH) && reg_wdata[0];

    // Store the configuration words on writes to their offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            dev_addr_q <= '0;
            len_q      <= '0;
            div_lo_q   <= '0;
            div_hi_q   <= '0;
            hold_q     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:   ctrl_q     <= word_to_ctrl(reg_wdata);
                A_ADDR:   dev_addr_q <= reg_wdata[DEVADDR_W-1:0];
                A_LEN:    len_q      <= reg_wdata[LEN_W-1:0];
                A_DIV_LO: div_lo_q   <= reg_wdata;
                A_DIV_HI: div_hi_q   <= reg_wdata;
                A_HOLD:   hold_q     <= reg_wdata[HOLD_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky done/NACK flags: engine pulse sets, status write of 0 clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            if (eng_done) begin
                pend_q <= 1'b1;
            end else if (stat_wr && !reg_wdata[SB_PEND]) begin
                pend_q <= 1'b0;
            end
            if (eng_nack) begin
                nack_q <= 1'b1;
            end else if (stat_wr && !reg_wdata[SB_NACK]) begin
                nack_q <= 1'b0;
            end
        end
    end

    // Assemble the status word from live inputs and sticky flags
    always_comb begin
        stat_word             = '0;
        stat_word[SB_BUSY]    = eng_busy;
        stat_word[SB_NACK]    = nack_q;
        stat_word[SB_PEND]    = pend_q;
        stat_word[SB_TXEMPTY] = tx_empty;
        stat_word[SB_RXFULL]  = rx_full;
        stat_word[SB_SCL]     = scl_in;
        stat_word[SB_SDA]     = sda_in;
    end

    // Select read data by offset; unmapped offsets read zero
    always_comb begin
        rd_word   = '0;
        rd_mapped = 1'b1;
        case (reg_addr)
            A_CTRL:   rd_word = ctrl_to_word(ctrl_q);
            A_ADDR:   rd_word = REG_W'(dev_addr_q);
            A_LEN:    rd_word = REG_W'(len_q);
            A_RXD:    rd_word = rx_empty ? '0 : REG_W'(rx_head);
            A_STAT:   rd_word = stat_word;
            A_DIV_LO: rd_word = div_lo_q;
            A_DIV_HI: rd_word = div_hi_q;
            A_HOLD:   rd_word = REG_W'(hold_q);
            default:  rd_mapped = 1'b0;
        endcase
    end

    // Capture read data on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_word;
        end
    end

    assign ctrl     = ctrl_q;
    assign pend     = pend_q;
    assign dev_addr = dev_addr_q;
    assign xfer_len = len_q;
    assign div_lo   = div_lo_q;
    assign div_hi   = div_hi_q;
    assign hold     = hold_q;

    // R7: a done pulse always leaves the pending flag set
    a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> pend_q);

    // R7: pending stays set unless a status write clears it
    a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !stat_wr) |=> pend_q);

    // R2: the control word changes only on a control write
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_CTRL)) |=> $stable(ctrl_q));

    // R12: unmapped reads return zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rd_mapped) |=> (reg_rdata == '0));

endmodule

// File: rtl/i2cfe_irq.sv
// Module: FIFO level comparators and the registered interrupt output.
// Compares queue occupancies with the programmed levels and merges them
// with the pending flag under the global enable. Assumes LVL_W <= CNT_W.
module i2cfe_irq
    import i2cfe_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             pend,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    output logic             irq
);
    logic af_hit;
    logic ae_hit;
    logic irq_q;

    // Level comparators, each gated by its own enable
    always_comb begin
        af_hit = ctrl.af_ie && (rx_level >= CNT_W'(ctrl.af_lvl));
        ae_hit = ctrl.ae_ie && (tx_level <= CNT_W'(ctrl.ae_lvl));
    end

    // Register the merged request so the output never glitches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= ctrl.irq_en && (pend || af_hit || ae_hit);
        end
    end

    assign irq = irq_q;

    // R11: no interrupt the cycle after the global enable was low
    a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |=> !irq);

    // R11: pending with global enable raises the interrupt
    a_r11_pend_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.irq_en && pend) |=> irq);

    // R9: receive level at or above the mark raises the interrupt
    a_r9_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.irq_en && ctrl.af_ie && (rx_level >= CNT_W'(ctrl.af_lvl))) |=> irq);

    // R10: transmit level at or below the mark raises the interrupt
    a_r10_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.irq_en && ctrl.ae_ie && (tx_level <= CNT_W'(ctrl.ae_lvl))) |=> irq);

endmodule

// File: rtl/i2c_fifo_regs.sv
// Module: top of the I2C master register front end.
// Connects the register decode, a transmit and a receive byte FIFO and
// the interrupt logic. Assumes the bus engine drives one-cycle take/put
// pulses and provides already synchronised line levels.
module i2c_fifo_regs
    import i2cfe_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8,
    parameter int DEVADDR_W  = 16,
    parameter int LEN_W      = 16,
    parameter int HOLD_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [DATA_W-1:0]    tx_head,
    output logic                 tx_avail,
    input  logic                 tx_take,
    input  logic                 rx_put,
    input  logic [DATA_W-1:0]    rx_byte,
    output logic                 rx_room,
    input  logic                 eng_busy,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    input  logic                 sda_in,
    input  logic                 scl_in,
    output logic                 cfg_start,
    output logic                 cfg_rd_dir,
    output logic                 cfg_stop_en,
    output logic [DEVADDR_W-1:0] cfg_dev_addr,
    output logic [LEN_W-1:0]     cfg_xfer_len,
    output logic [31:0]          cfg_div_lo,
    output logic [31:0]          cfg_div_hi,
    output logic [HOLD_W-1:0]    cfg_hold,
    output logic                 irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t             ctrl;
    logic              pend;
    logic              tx_push;
    logic [DATA_W-1:0] tx_wbyte;
    logic              tx_empty;
    logic              tx_full;
    logic [CNT_W-1:0]  tx_level;
    logic              rx_pop;
    logic [DATA_W-1:0] rx_head;
    logic              rx_empty;
    logic              rx_full;
    logic [CNT_W-1:0]  rx_level;
    logic              fifo_flush;
    logic              tx_full_unused;

    i2cfe_regs #(
        .ADDR_W    (ADDR_W),
        .DEVADDR_W (DEVADDR_W),
        .LEN_W     (LEN_W),
        .HOLD_W    (HOLD_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .tx_push    (tx_push),
        .tx_wbyte   (tx_wbyte),
        .tx_empty   (tx_empty),
        .rx_pop     (rx_pop),
        .rx_head    (rx_head),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .fifo_flush (fifo_flush),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .sda_in     (sda_in),
        .scl_in     (scl_in),
        .ctrl       (ctrl),
        .pend       (pend),
        .dev_addr   (cfg_dev_addr),
        .xfer_len   (cfg_xfer_len),
        .div_lo     (cfg_div_lo),
        .div_hi     (cfg_div_hi),
        .hold       (cfg_hold)
    );

    i2cfe_byte_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (tx_push),
        .push_data (tx_wbyte),
        .pop       (tx_take),
        .head      (tx_head),
        .level     (tx_level),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    i2cfe_byte_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (rx_put),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_level),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    i2cfe_irq #(
        .CNT_W (CNT_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .pend     (pend),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .irq      (irq)
    );

    assign tx_full_unused = tx_full;
    assign tx_avail       = ~tx_empty;
    assign rx_room        = ~rx_full;
    assign cfg_start      = ctrl.start;
    assign cfg_rd_dir     = ctrl.rd_dir;
    assign cfg_stop_en    = ctrl.stop_en;

endmodule

// File: tb/tb_i2c_fifo_regs.sv
`timescale 1ns/1ps
// Bench: directed checks plus full sweeps of both level thresholds
// against every queue occupancy, expected values computed here.
module tb_i2c_fifo_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_head;
    logic        tx_avail;
    logic        tx_take;
    logic        rx_put;
    logic [7:0]  rx_byte;
    logic        rx_room;
    logic        eng_busy, eng_done, eng_nack, sda_in, scl_in;
    logic        cfg_start, cfg_rd_dir, cfg_stop_en;
    logic [15:0] cfg_dev_addr, cfg_xfer_len, cfg_hold;
    logic [31:0] cfg_div_lo, cfg_div_hi;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_fifo_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_head(tx_head), .tx_avail(tx_avail), .tx_take(tx_take),
        .rx_put(rx_put), .rx_byte(rx_byte), .rx_room(rx_room),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_nack(eng_nack),
        .sda_in(sda_in), .scl_in(scl_in), .cfg_start(cfg_start),
        .cfg_rd_dir(cfg_rd_dir), .cfg_stop_en(cfg_stop_en),
        .cfg_dev_addr(cfg_dev_addr), .cfg_xfer_len(cfg_xfer_len),
        .cfg_div_lo(cfg_div_lo), .cfg_div_hi(cfg_div_hi),
        .cfg_hold(cfg_hold), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_put = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic tx_out();
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] LINES = 32'h0030_0000;

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        tx_take = 0; rx_put = 0; rx_byte = '0; eng_busy = 0; eng_done = 0;
        eng_nack = 0; sda_in = 1; scl_in = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        bus_rd(8'h14, d); chk("R1 status", d, LINES | 32'h8);
        bus_rd(8'h20, d); chk("R1 div_lo", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_avail", {31'b0, tx_avail}, 32'h0);
        chk("R1 rx_room", {31'b0, rx_room}, 32'h1);

        // R2: control fields and readback mask
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_rd(8'h00, d); chk("R2 ctrl mask", d, 32'h001F_F60B);
        chk("R2 cfg bits", {29'b0, cfg_start, cfg_rd_dir, cfg_stop_en}, 32'h7);
        bus_wr(8'h00, 32'h0010_0008);
        bus_rd(8'h00, d); chk("R2 ctrl stop+dir", d, 32'h0010_0008);
        chk("R2 cfg bits 2", {29'b0, cfg_start, cfg_rd_dir, cfg_stop_en}, 32'h3);
        bus_wr(8'h00, 32'h0);

        // R3: configuration words
        bus_wr(8'h04, 32'hABCD_1234);
        bus_wr(8'h08, 32'hFFFF_5A5A);
        bus_wr(8'h20, 32'hDEAD_BEEF);
        bus_wr(8'h24, 32'h0123_4567);
        bus_wr(8'h28, 32'h9999_0042);
        bus_rd(8'h04, d); chk("R3 addr", d, 32'h1234);
        bus_rd(8'h08, d); chk("R3 len", d, 32'h5A5A);
        bus_rd(8'h20, d); chk("R3 div_lo", d, 32'hDEAD_BEEF);
        bus_rd(8'h24, d); chk("R3 div_hi", d, 32'h0123_4567);
        bus_rd(8'h28, d); chk("R3 hold", d, 32'h0042);
        chk("R3 cfg_dev_addr", {16'b0, cfg_dev_addr}, 32'h1234);
        chk("R3 cfg_xfer_len", {16'b0, cfg_xfer_len}, 32'h5A5A);
        chk("R3 cfg_div", cfg_div_lo ^ cfg_div_hi, 32'hDEAD_BEEF ^ 32'h0123_4567);
        chk("R3 cfg_hold", {16'b0, cfg_hold}, 32'h0042);

        // R12: unmapped offsets
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        bus_rd(8'h18, d); chk("R12 read 0x18", d, 32'h0);
        bus_rd(8'h1C, d); chk("R12 read 0x1C", d, 32'h0);
        bus_rd(8'h00, d); chk("R12 ctrl untouched", d, 32'h0);
        bus_rd(8'h04, d); chk("R12 addr untouched", d, 32'h1234);

        // R4: transmit ordering and overflow drop
        for (int i = 0; i < 17; i++) bus_wr(8'h0C, {24'hFFFFFF, 8'(8'h10 + i * 3)});
        bus_rd(8'h14, d); chk("R4 status tx not empty", d & 32'h8, 32'h0);
        for (int i = 0; i < 16; i++) begin
            chk("R4 tx_avail", {31'b0, tx_avail}, 32'h1);
            chk("R4 tx order", {24'b0, tx_head}, {24'b0, 8'(8'h10 + i * 3)});
            tx_out();
        end
        chk("R4 17th dropped", {31'b0, tx_avail}, 32'h0);

        // R5: receive ordering, overflow drop, empty read
        for (int i = 0; i < 17; i++) rx_in(8'(8'hA0 ^ (i * 7)));
        chk("R5 rx_room full", {31'b0, rx_room}, 32'h0);
        bus_rd(8'h14, d); chk("R6 status rx full", d & 32'h10, 32'h10);
        for (int i = 0; i < 16; i++) begin
            bus_rd(8'h10, d); chk("R5 rx order", d, {24'b0, 8'(8'hA0 ^ (i * 7))});
        end
        bus_rd(8'h10, d); chk("R5 empty read", d, 32'h0);
        bus_rd(8'h10, d); chk("R5 empty read again", d, 32'h0);
        bus_rd(8'h14, d); chk("R6 status rx not full", d & 32'h10, 32'h0);
        rx_in(8'h5C);
        bus_rd(8'h10, d); chk("R5 after empty read", d, 32'h5C);
        bus_rd(8'h10, d); chk("R5 drained", d, 32'h0);

        // R6: live status bits
        eng_busy = 1; sda_in = 0; scl_in = 1;
        bus_rd(8'h14, d); chk("R6 busy/scl", d, 32'h0010_0009);
        eng_busy = 0; sda_in = 1; scl_in = 0;
        bus_rd(8'h14, d); chk("R6 sda", d, 32'h0020_0008);
        scl_in = 1;

        // R7 / R11: sticky flags and gating
        eng_done = 1; @(negedge clk); eng_done = 0;
        bus_rd(8'h14, d); chk("R7 pending set", d, LINES | 32'hC);
        @(negedge clk);
        chk("R11 gated off", {31'b0, irq}, 32'h0);
        bus_wr(8'h14, 32'h4);
        bus_rd(8'h14, d); chk("R7 write 1 keeps", d & 32'h4, 32'h4);
        bus_wr(8'h00, 32'h2);
        @(negedge clk);
        chk("R11 pending irq", {31'b0, irq}, 32'h1);
        bus_wr(8'h14, 32'h0);
        @(negedge clk);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
        bus_rd(8'h14, d); chk("R7 pending cleared", d & 32'h4, 32'h0);
        eng_nack = 1; @(negedge clk); eng_nack = 0;
        bus_rd(8'h14, d); chk("R7 nack set", d & 32'h6, 32'h2);
        @(negedge clk);
        chk("R11 nack no irq", {31'b0, irq}, 32'h0);
        bus_wr(8'h14, 32'h4);
        bus_rd(8'h14, d); chk("R7 nack cleared", d & 32'h2, 32'h0);
        reg_addr = 8'h14; reg_wdata = 32'h0; reg_wr = 1; eng_done = 1;
        @(negedge clk);
        reg_wr = 0; eng_done = 0;
        bus_rd(8'h14, d); chk("R7 set wins", d & 32'h4, 32'h4);
        bus_wr(8'h14, 32'h0);
        bus_wr(8'h00, 32'h0);

        // R8: flush
        for (int i = 0; i < 3; i++) begin
            bus_wr(8'h0C, 32'(i + 1));
            rx_in(8'(8'h30 + i));
        end
        bus_wr(8'h2C, 32'h0);
        chk("R8 flush 0 ignored", {31'b0, tx_avail}, 32'h1);
        bus_rd(8'h10, d); chk("R8 flush 0 rx kept", d, 32'h30);
        bus_wr(8'h2C, 32'h1);
        chk("R8 tx flushed", {31'b0, tx_avail}, 32'h0);
        bus_rd(8'h10, d); chk("R8 rx flushed", d, 32'h0);
        bus_rd(8'h14, d); chk("R8 status tx empty", d & 32'h8, 32'h8);

        // R9: sweep almost-full level against receive occupancy
        for (int lvl = 0; lvl < 16; lvl++) begin
            bus_wr(8'h2C, 32'h1);
            bus_wr(8'h00, 32'h402 | (32'(lvl) << 16));
            @(negedge clk);
            for (int c = 0; c <= 16; c++) begin
                if (c > 0) begin
                    rx_in(8'(c));
                    @(negedge clk);
                end
                chk("R9 full level", {31'b0, irq}, {31'b0, (c >= lvl)});
            end
            rx_in(8'hEE);
            @(negedge clk);
            chk("R9 at depth", {31'b0, irq}, 32'h1);
        end

        // R10: sweep almost-empty level against transmit occupancy
        for (int lvl = 0; lvl < 16; lvl++) begin
            bus_wr(8'h2C, 32'h1);
            bus_wr(8'h00, 32'h202 | (32'(lvl) << 12));
            @(negedge clk);
            for (int c = 0; c <= 16; c++) begin
                if (c > 0) begin
                    bus_wr(8'h0C, 32'(c));
                    @(negedge clk);
                end
                chk("R10 empty level", {31'b0, irq}, {31'b0, (c <= lvl)});
            end
        end

        // R11: global enable gates a true level condition
        bus_wr(8'h2C, 32'h1);
        bus_wr(8'h00, 32'h400);
        @(negedge clk);
        chk("R11 level gated", {31'b0, irq}, 32'h0);
        bus_wr(8'h00, 32'h402);
        @(negedge clk);
        chk("R11 level enabled", {31'b0, irq}, 32'h1);
        bus_wr(8'h00, 32'h0);
        @(negedge clk);
        chk("R11 disabled again", {31'b0, irq}, 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule